// File: doc/BRIEF.md
# Reset Delay and SIM Supply Sequencer

This block decides when the host processor leaves reset and when the SIM card supply may be switched on, and at which of the two SIM voltages. A power-good flag from the digital supply starts a reset delay whose length is programmed as a capacitance value in nF. The delay is counted on a 1 kHz tick that a prescaler derives from the system clock. One programmed nF gives one tick, so 1 ms per nF. A value of 100 therefore holds reset for about 100 ms after the supply becomes good.

The SIM supply enable is interlocked behind three conditions: the digital supply is good, the reset has been released, and software requests the SIM. The 3 V / 5 V choice is latched from the select input only while the supply is off. The gate for the SIM-side reset, clock and data paths opens one tick after the supply comes on, and it closes as soon as the supply goes off.

Top module: `pwr_rst_sim_seq`

## Requirements
- R1: After the asynchronous reset, and at any time while `vdd_good` is low, `sys_rst_n`, `sim_pwr_en`, `sim_5v_sel` and `sim_io_gate` are all 0.
- R2: With `P` clocks per tick and a delay value `D`, the rise of `sys_rst_n` (sampled on falling clock edges) comes between `(D-1)*P+3` and `D*P+2` clock cycles after `vdd_good` rises. For `D` = 0 it comes exactly 2 cycles after.
- R3: When `vdd_good` falls, `sys_rst_n`, `sim_pwr_en` and `sim_io_gate` go to 0 in the same cycle, before any clock edge.
- R4: If `vdd_good` drops while the delay is running, the count is discarded. The next rise of `vdd_good` starts a full delay again.
- R5: `sim_pwr_en` is 1 exactly when `vdd_good`, `sys_rst_n` and `sim_req` are all 1, and it follows them combinationally.
- R6: `sim_5v_sel` is 1 for 5 V and 0 for 3 V. While the supply is on, it shows the level of `sim_hi_sel` captured at the last clock edge at which the supply was off. It is 0 while the supply is off.
- R7: A change of `sim_hi_sel` while `sim_pwr_en` is 1 does not change `sim_5v_sel` until the supply has been switched off and on again.
- R8: `sim_io_gate` is 0 in the cycle `sim_pwr_en` rises. It becomes 1 no more than `P` cycles later, and it is 0 whenever `sim_pwr_en` is 0.
- R9: The delay value is captured when the count starts. A change of `dly_nf` during the count does not change the release time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vdd_good | input | 1 | Digital supply power-good flag |
| sim_req | input | 1 | Request to power the SIM card |
| sim_hi_sel | input | 1 | SIM level request: 0 = 3 V, 1 = 5 V |
| dly_nf | input | DLY_W | Programmed reset-delay capacitance in nF (one tick per nF) |
| sys_rst_n | output | 1 | Active-low processor reset |
| sim_pwr_en | output | 1 | SIM supply enable |
| sim_5v_sel | output | 1 | SIM level: 0 = 3 V, 1 = 5 V |
| sim_io_gate | output | 1 | Enable for the SIM-side reset, clock and data paths |

## Verification
The case that is hardest to reach from the ports is a power-good drop part way through the delay count. It only shows up if the remainder of the old count would release reset early on the next attempt. The stimulus raises the flag, drops it after ten cycles while reset is still low, raises it again, and requires the release to fall inside the full window measured from the second rise. The tick phase is not visible at the ports, so every delay check uses a window one tick wide rather than one exact cycle. A separate run changes the delay value during the count to show that the value captured at the start is the one used.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } dly_state_e;
endpackage

// File: rtl/prd_tick_gen.sv
module prd_tick_gen #(
  parameter int CLK_PER_TICK = 125000
) (
  input  logic clk,
  input  logic arst_n,
  output logic tick
);
  localparam int CW = (CLK_PER_TICK > 2) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/prd_rst_delay.sv
module prd_rst_delay
  import prd_pkg::*;
#(
  parameter int DLY_W = 10
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             tick,
  input  logic             pwr_good,
  input  logic [DLY_W-1:0] dly_val,
  output logic             rst_out_n
);
  dly_state_e       state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] tgt_q, tgt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tgt_d   = tgt_q;
    if (!pwr_good) begin
      state_d = ST_HOLD;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_HOLD: begin
          state_d = ST_COUNT;
          cnt_d   = '0;
          tgt_d   = dly_val;
        end
        ST_COUNT: begin
          if (cnt_q == tgt_q)  state_d = ST_RUN;
          else if (tick)       cnt_d   = cnt_q + 1'b1;
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tgt_q   <= tgt_d;
    end
  end

  // power loss drops reset without waiting for a clock edge
  assign rst_out_n = (state_q == ST_RUN) && pwr_good;
endmodule

// File: rtl/prd_sim_ctrl.sv
module prd_sim_ctrl (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic pwr_good,
  input  logic rst_in_n,
  input  logic req,
  input  logic hi_sel,
  output logic pwr_en,
  output logic sel_5v,
  output logic io_gate
);
  logic allow;
  logic sel_q, sel_d;
  logic armed_q, armed_d;

  always_comb begin
    allow   = pwr_good && rst_in_n && req;
    // level is captured only while the supply is off
    sel_d   = allow ? sel_q : hi_sel;
    // gate arms on a tick seen while the supply is allowed
    armed_d = allow && (armed_q || tick);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sel_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      armed_q <= armed_d;
    end
  end

  assign pwr_en  = allow;
  assign sel_5v  = allow && sel_q;
  assign io_gate = allow && armed_q;
endmodule

// File: rtl/pwr_rst_sim_seq.sv
module pwr_rst_sim_seq #(
  parameter int CLK_PER_TICK = 125000,
  parameter int DLY_W        = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vdd_good,
  input  logic             sim_req,
  input  logic             sim_hi_sel,
  input  logic [DLY_W-1:0] dly_nf,
  output logic             sys_rst_n,
  output logic             sim_pwr_en,
  output logic             sim_5v_sel,
  output logic             sim_io_gate
);
  logic [1:0] rsync_q;
  logic       arst_n;
  logic       tick;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  prd_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk    (clk),
    .arst_n (arst_n),
    .tick   (tick)
  );

  prd_rst_delay #(.DLY_W(DLY_W)) u_dly (
    .clk       (clk),
    .arst_n    (arst_n),
    .tick      (tick),
    .pwr_good  (vdd_good),
    .dly_val   (dly_nf),
    .rst_out_n (rst_int_n)
  );

  prd_sim_ctrl u_sim (
    .clk      (clk),
    .arst_n   (arst_n),
    .tick     (tick),
    .pwr_good (vdd_good),
    .rst_in_n (rst_int_n),
    .req      (sim_req),
    .hi_sel   (sim_hi_sel),
    .pwr_en   (sim_pwr_en),
    .sel_5v   (sim_5v_sel),
    .io_gate  (sim_io_gate)
  );

  assign sys_rst_n = rst_int_n;
endmodule

// File: rtl/pwr_rst_sim_seq_chk.sv
module pwr_rst_sim_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic vdd_good,
  input logic sim_req,
  input logic sys_rst_n,
  input logic sim_pwr_en,
  input logic sim_5v_sel,
  input logic sim_io_gate
);
  p_rst_low_nopwr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !vdd_good |-> !sys_rst_n && !sim_pwr_en);

  p_release_after_good_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(vdd_good));

  p_sim_interlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sim_pwr_en |-> vdd_good && sys_rst_n && sim_req);

  p_sel_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sim_pwr_en |-> !sim_5v_sel);

  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sim_pwr_en && $past(sim_pwr_en) |-> $stable(sim_5v_sel));

  p_gate_in_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sim_io_gate |-> sim_pwr_en);

  p_gate_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sim_pwr_en) |-> !sim_io_gate);
endmodule

bind pwr_rst_sim_seq pwr_rst_sim_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vdd_good    (vdd_good),
  .sim_req     (sim_req),
  .sys_rst_n   (sys_rst_n),
  .sim_pwr_en  (sim_pwr_en),
  .sim_5v_sel  (sim_5v_sel),
  .sim_io_gate (sim_io_gate)
);

// File: tb/pwr_rst_sim_seq_tb.sv
module pwr_rst_sim_seq_tb;
  localparam int P = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n, vdd_good, sim_req, sim_hi_sel;
  logic [DW-1:0] dly_nf;
  logic sys_rst_n, sim_pwr_en, sim_5v_sel, sim_io_gate;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_rst_sim_seq #(.CLK_PER_TICK(P), .DLY_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .vdd_good(vdd_good), .sim_req(sim_req),
    .sim_hi_sel(sim_hi_sel), .dly_nf(dly_nf), .sys_rst_n(sys_rst_n),
    .sim_pwr_en(sim_pwr_en), .sim_5v_sel(sim_5v_sel), .sim_io_gate(sim_io_gate)
  );

  // {req, sel, exp_pwr_en, exp_5v, exp_gate}
  localparam logic [4:0] VEC [8] = '{
    5'b00_000,  // off, 3 V requested (R5)
    5'b10_101,  // on at 3 V (R6, R8)
    5'b11_101,  // select flipped while on: ignored (R7)
    5'b01_000,  // off, 5 V captured (R6)
    5'b11_111,  // on at 5 V (R6)
    5'b10_111,  // select flipped while on: ignored (R7)
    5'b00_000,  // off again (R5)
    5'b10_101   // back on at 3 V (R7)
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // raise power-good with delay d and check the release window
  task automatic measure(input int d, input bit change, input string req);
    int n = 0;
    int leak = 0;
    int lo = (d == 0) ? 2 : (d - 1) * P + 3;
    int hi = d * P + 2;
    dly_nf = DW'(d);
    vdd_good = 1'b1;
    while (!sys_rst_n && n < 4000) begin
      @(negedge clk);
      n++;
      if (n == 2 && change) dly_nf = 8'd200;
      if (!sys_rst_n && sim_pwr_en) leak++;
    end
    chk(n >= lo && n <= hi, req, n, (n < lo) ? lo : hi);
    chk(leak == 0, "R5 (supply during delay)", leak, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; vdd_good = 1'b0; sim_req = 1'b0; sim_hi_sel = 1'b0; dly_nf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(sys_rst_n == 0, "R1 sys_rst_n", sys_rst_n, 0);
    chk(sim_pwr_en == 0 && sim_5v_sel == 0 && sim_io_gate == 0, "R1 sim outputs",
        {sim_pwr_en, sim_5v_sel, sim_io_gate}, 0);

    // R5: request without power
    sim_req = 1'b1;
    repeat (2) @(negedge clk);
    chk(sim_pwr_en == 0, "R5 no power", sim_pwr_en, 0);

    // R2 and R9: delay 5, value changed mid-count
    measure(5, 1'b1, "R2/R9 release window");
    repeat (P + 2) @(negedge clk);
    chk(sim_pwr_en == 1 && sim_io_gate == 1, "R5 enabled after release",
        {sim_pwr_en, sim_io_gate}, 3);

    // R3: power loss drops everything at once
    vdd_good = 1'b0;
    #1;
    chk(sys_rst_n == 0, "R3 reset immediate", sys_rst_n, 0);
    chk(sim_pwr_en == 0, "R3 supply immediate", sim_pwr_en, 0);
    chk(sim_io_gate == 0, "R8 gate closes with supply", sim_io_gate, 0);
    @(negedge clk);

    // R4: interrupted count restarts in full
    dly_nf = 8'd6;
    vdd_good = 1'b1;
    repeat (10) @(negedge clk);
    chk(sys_rst_n == 0, "R4 still in delay", sys_rst_n, 0);
    vdd_good = 1'b0;
    @(negedge clk);
    measure(6, 1'b0, "R4 full delay after drop");

    // R2: zero delay
    vdd_good = 1'b0;
    @(negedge clk);
    measure(0, 1'b0, "R2 zero delay");

    // table walk with supply good and reset released
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sim_req = VEC[i][4];
      sim_hi_sel = VEC[i][3];
      repeat (P + 4) @(negedge clk);
      chk(sim_pwr_en == VEC[i][2], $sformatf("R5 vec%0d", i), sim_pwr_en, VEC[i][2]);
      chk(sim_5v_sel == VEC[i][1], $sformatf("R6/R7 vec%0d", i), sim_5v_sel, VEC[i][1]);
      chk(sim_io_gate == VEC[i][0], $sformatf("R8 vec%0d", i), sim_io_gate, VEC[i][0]);
    end

    // R8: gate opening latency
    sim_req = 1'b0;
    repeat (3) @(negedge clk);
    sim_req = 1'b1;
    #1;
    chk(sim_pwr_en == 1 && sim_io_gate == 0, "R8 gate closed at enable",
        {sim_pwr_en, sim_io_gate}, 2);
    begin
      int n = 0;
      while (!sim_io_gate && n < 100) begin
        @(negedge clk);
        n++;
      end
      chk(n >= 1 && n <= P, "R8 gate latency", n, P);
    end

    finish_run();
  end
endmodule